// File: doc/BRIEF.md
# Wide Leading-One Locator

This block reports the position of the highest set bit in a very wide input word. A single-cycle priority encoder over a 1024-bit word would be too deep for a fast clock, so the search is split into registered steps over fixed-width blocks (16 bits each by default). A pulse on `start_i` captures the word and the operating mode. When the search ends, `done_o` pulses for one cycle and `pos_o`/`hit_o` carry the result.

Two operating modes are available. In the parallel mode every block is encoded at once and registered, and the second cycle merges the per-block results through a logarithmic tree. In the serial mode a single block encoder walks the captured word one block per clock, starting at the top. It stops at the first nonzero block, so its latency depends on the data. The number of significant bits in the word is `pos_o + 1` whenever `hit_o` is high.

Top module: `msb_locate`

## Requirements
- R1: While reset is asserted and after it is released with no start, `pos_o` is 0, `hit_o` is 0 and `done_o` is 0.
- R2: In parallel mode (`serial_i` = 0 when `start_i` is taken), `done_o` is high during the cycle after the second rising edge counted from the start edge itself, so latency is 2 clocks for every input value.
- R3: When the captured word has at least one set bit, `hit_o` is 1 and `pos_o` is the index of the highest set bit, with bit 0 as the least significant bit and bit 1023 reported as 1023.
- R4: When the captured word is all zero, `hit_o` is 0 and `pos_o` is 0.
- R5: In serial mode (`serial_i` = 1 when `start_i` is taken), latency is 2 + (63 − b) clocks, where b = floor(index/16) is the block that holds the highest set bit. An all-zero word takes 65 clocks.
- R6: A `start_i` that arrives while a search is in progress is ignored. The running search returns the result for its own word with its own latency, and no extra `done_o` follows.
- R7: `done_o` is high for exactly one cycle per accepted start. `pos_o` and `hit_o` keep their values until the next `done_o`, whatever `vec_i` and `serial_i` do meanwhile.
- R8: The mode is sampled only when the start is taken. A change on `serial_i` during a search does not change its latency or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| serial_i | input | 1 | Mode select, sampled with start: 1 = block-per-clock scan, 0 = parallel two-step |
| start_i | input | 1 | Begin a search on `vec_i`; taken only when idle |
| vec_i | input | 1024 | Word to search, sampled with start |
| pos_o | output | 10 | Index of the highest set bit |
| hit_o | output | 1 | High when the word had any set bit |
| done_o | output | 1 | One-cycle pulse when `pos_o`/`hit_o` are updated |

## Verification
The assertions assume that the mode and word are meaningful only in the cycle where a start is taken. They also assume that `start_i` is a clean synchronous level that changes away from the clock edge. The bench drives every input on the falling edge. It raises `start_i` only for the chosen cycles, and it deliberately toggles the mode, the word and a second start while a search runs, to show that these changes are ignored. The bench uses single-bit, multi-bit and all-zero words that place the top bit at both ends of the word and at block boundaries. These are the cases where a block or tree index could be off by one.

// File: rtl/msb_locate_pkg.sv
package msb_locate_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MERGE = 2'd1,
      ST_SCAN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/msb_tree.sv
// Logarithmic priority tree: each level merges pairs, preferring the upper one.
module msb_tree #(
   parameter int unsigned LEAVES = 16,
   localparam int unsigned IX_W = $clog2(LEAVES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEAVES-1:0] leaf_i,
   output logic              any_o,
   output logic [IX_W-1:0]   ix_o
);
   if (LEAVES < 2 || (1 << IX_W) != LEAVES) begin : g_bad_leaves
      $error("msb_tree: LEAVES must be a power of two of at least 2");
   end

   for (genvar l = 0; l <= IX_W; l++) begin : g_lvl
      localparam int unsigned CNT = LEAVES >> l;
      logic [CNT-1:0]  v;
      logic [IX_W-1:0] ix [CNT];
      if (l == 0) begin : g_leaf
         assign v = leaf_i;
         for (genvar i = 0; i < CNT; i++) begin : g_z
            assign ix[i] = '0;
         end
      end else begin : g_node
         for (genvar i = 0; i < CNT; i++) begin : g_pair
            assign v[i]  = g_lvl[l-1].v[2*i] | g_lvl[l-1].v[2*i+1];
            assign ix[i] = g_lvl[l-1].v[2*i+1]
                         ? (g_lvl[l-1].ix[2*i+1] | (IX_W'(1) << (l-1)))
                         : g_lvl[l-1].ix[2*i];
         end
      end
   end

   assign any_o = g_lvl[IX_W].v[0];
   assign ix_o  = g_lvl[IX_W].ix[0];

   // R3: reported leaf is set and nothing above it is set
   a_r3_leaf_set: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> leaf_i[ix_o]);
   a_r3_none_above: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> ((leaf_i >> ix_o) == LEAVES'(1)));
endmodule

// File: rtl/msb_blk_stage.sv
// Parallel first step: encode every block at once and register the results.
module msb_blk_stage #(
   parameter int unsigned DATA_W = 1024,
   parameter int unsigned BLK_W  = 16,
   localparam int unsigned NUM_BLK = DATA_W / BLK_W,
   localparam int unsigned OFF_W   = $clog2(BLK_W)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_i,
   input  logic [DATA_W-1:0]             vec_i,
   output logic [NUM_BLK-1:0]            blk_any_o,
   output logic [NUM_BLK-1:0][OFF_W-1:0] blk_off_o
);
   logic [NUM_BLK-1:0]            any_d;
   logic [NUM_BLK-1:0][OFF_W-1:0] off_d;

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      msb_tree #(.LEAVES(BLK_W)) enc_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .leaf_i (vec_i[b*BLK_W +: BLK_W]),
         .any_o  (any_d[b]),
         .ix_o   (off_d[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_any_o <= '0;
         blk_off_o <= '0;
      end else if (load_i) begin
         blk_any_o <= any_d;
         blk_off_o <= off_d;
      end
   end

   // R2: registered block flags follow the loaded word
   a_r2_stage_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (blk_any_o == $past(any_d)));
endmodule

// File: rtl/msb_locate.sv
module msb_locate #(
   parameter int unsigned DATA_W = 1024,
   parameter int unsigned BLK_W  = 16,
   localparam int unsigned NUM_BLK = DATA_W / BLK_W,
   localparam int unsigned OFF_W   = $clog2(BLK_W),
   localparam int unsigned BI_W    = $clog2(NUM_BLK),
   localparam int unsigned POS_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              serial_i,
   input  logic              start_i,
   input  logic [DATA_W-1:0] vec_i,
   output logic [POS_W-1:0]  pos_o,
   output logic              hit_o,
   output logic              done_o
);
   import msb_locate_pkg::*;

   if (DATA_W % BLK_W != 0 || NUM_BLK < 2 || (1 << BI_W) != NUM_BLK) begin : g_bad_cfg
      $error("msb_locate: DATA_W/BLK_W must be a power of two of at least 2");
   end

   seq_state_e           state_q;
   logic [BI_W-1:0]      ptr_q;
   logic [DATA_W-1:0]    scan_q;
   logic                 take;
   logic                 par_load;

   assign take     = start_i && (state_q == ST_IDLE);
   assign par_load = take && !serial_i;

   // parallel path
   logic [NUM_BLK-1:0]            blk_any;
   logic [NUM_BLK-1:0][OFF_W-1:0] blk_off;
   logic                          mrg_any;
   logic [BI_W-1:0]               mrg_blk;

   msb_blk_stage #(.DATA_W(DATA_W), .BLK_W(BLK_W)) stage_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (par_load),
      .vec_i     (vec_i),
      .blk_any_o (blk_any),
      .blk_off_o (blk_off)
   );

   msb_tree #(.LEAVES(NUM_BLK)) merge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .leaf_i (blk_any),
      .any_o  (mrg_any),
      .ix_o   (mrg_blk)
   );

   // serial path: one encoder on the top block of a shifting copy
   logic              top_any;
   logic [OFF_W-1:0]  top_off;

   msb_tree #(.LEAVES(BLK_W)) scan_enc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .leaf_i (scan_q[DATA_W-1 -: BLK_W]),
      .any_o  (top_any),
      .ix_o   (top_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         scan_q  <= '0;
         pos_o   <= '0;
         hit_o   <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (take) begin
                  if (serial_i) begin
                     scan_q  <= vec_i;
                     ptr_q   <= BI_W'(NUM_BLK - 1);
                     state_q <= ST_SCAN;
                  end else begin
                     state_q <= ST_MERGE;
                  end
               end
            end
            ST_MERGE: begin
               pos_o   <= mrg_any ? {mrg_blk, blk_off[mrg_blk]} : '0;
               hit_o   <= mrg_any;
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_SCAN: begin
               if (top_any || ptr_q == '0) begin
                  pos_o   <= top_any ? {ptr_q, top_off} : '0;
                  hit_o   <= top_any;
                  done_o  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  scan_q <= scan_q << BLK_W;
                  ptr_q  <= ptr_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2: parallel search answers on the second edge after the start edge
   a_r2_par_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q == ST_IDLE && !serial_i) |=> ##1 done_o);
   // R7: completion is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7: result is held between completions
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(pos_o) && $stable(hit_o)));
   // R4: no hit means index zero
   a_r4_zero_pos: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (pos_o == '0));
   // R5: each continued scan cycle moves one block down
   a_r5_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SCAN && $past(state_q) == ST_SCAN)
         |-> (ptr_q == BI_W'($past(ptr_q) - 1'b1)));
   // R6: a start while busy does not reach idle-only capture
   a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_MERGE) |=> (state_q == ST_IDLE));
endmodule

// File: tb/msb_locate_tb.sv
module msb_locate_tb_top;
   localparam int DW = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          serial_i = 1'b0;
   logic          start_i = 1'b0;
   logic [DW-1:0] vec_i = '0;
   logic [9:0]    pos_o;
   logic          hit_o;
   logic          done_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   msb_locate dut_i (
      .clk(clk), .rst_n(rst_n), .serial_i(serial_i), .start_i(start_i),
      .vec_i(vec_i), .pos_o(pos_o), .hit_o(hit_o), .done_o(done_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_pos(input logic [DW-1:0] v);
      int r = 0;
      for (int i = 0; i < DW; i++) if (v[i]) r = i;
      return r;
   endfunction

   function automatic int ref_lat(input bit ser, input logic [DW-1:0] v);
      if (!ser) return 2;
      if (v == '0) return 65;
      return 2 + (63 - ref_pos(v) / 16);
   endfunction

   task automatic run_op(input bit ser, input logic [DW-1:0] v, output int lat);
      @(negedge clk);
      serial_i = ser; vec_i = v; start_i = 1'b1;
      @(posedge clk); lat = 1;
      @(negedge clk); start_i = 1'b0;
      while (!done_o && lat < 200) begin
         @(posedge clk); lat++;
         @(negedge clk);
      end
   endtask

   task automatic op_check(input string tag, input bit ser, input logic [DW-1:0] v);
      int lat;
      run_op(ser, v, lat);
      chk({tag, " R3/R4 hit"}, int'(hit_o), int'(|v));
      chk({tag, " R3/R4 pos"}, int'(pos_o), (|v) ? ref_pos(v) : 0);
      chk({tag, ser ? " R5 latency" : " R2 latency"}, lat, ref_lat(ser, v));
   endtask

   function automatic logic [DW-1:0] one_bit(input int b);
      logic [DW-1:0] v = '0;
      v[b] = 1'b1;
      return v;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk("R1 pos in reset", int'(pos_o), 0);
      chk("R1 done in reset", int'(done_o), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 hit after reset", int'(hit_o), 0);
      chk("R1 done after reset", int'(done_o), 0);
   endtask

   task automatic t_parallel();
      logic [DW-1:0] v;
      op_check("par top bit R3", 1'b0, one_bit(1023));
      op_check("par bit0 R3", 1'b0, one_bit(0));
      op_check("par bit15", 1'b0, one_bit(15));
      op_check("par bit16", 1'b0, one_bit(16));
      v = one_bit(700) | one_bit(5) | one_bit(0) | one_bit(699);
      op_check("par multi", 1'b0, v);
      v = '0;
      for (int i = 0; i < DW; i += 37) v[i] = 1'b1;
      op_check("par spread", 1'b0, v);
      op_check("par zero R4", 1'b0, '0);
   endtask

   task automatic t_serial();
      op_check("ser top R5", 1'b1, one_bit(1023));
      op_check("ser bit0 R5", 1'b1, one_bit(0));
      op_check("ser mid", 1'b1, one_bit(500) | one_bit(3));
      op_check("ser blk edge", 1'b1, one_bit(512));
      op_check("ser zero R4", 1'b1, '0);
   endtask

   task automatic t_restart_ignored();
      int extra = 0;
      @(negedge clk);
      serial_i = 1'b0; vec_i = one_bit(300); start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      serial_i = 1'b1; vec_i = one_bit(900);   // second start while busy
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk("R6 done on time", int'(done_o), 1);
      chk("R6 pos from first word", int'(pos_o), 300);
      for (int i = 0; i < 70; i++) begin
         @(negedge clk);
         if (done_o) extra++;
      end
      chk("R6 no extra done", extra, 0);
   endtask

   task automatic t_mode_change();
      int lat;
      @(negedge clk);
      serial_i = 1'b1; vec_i = one_bit(2); start_i = 1'b1;
      @(posedge clk); lat = 1;
      @(negedge clk); start_i = 1'b0; serial_i = 1'b0; vec_i = one_bit(1000);
      while (!done_o && lat < 200) begin
         @(posedge clk); lat++;
         @(negedge clk);
      end
      chk("R8 serial latency kept", lat, 65);
      chk("R8 pos kept", int'(pos_o), 2);
   endtask

   task automatic t_hold();
      int pulses = 0;
      logic [9:0] p;
      op_check("hold setup", 1'b0, one_bit(77));
      p = pos_o;
      chk("R7 done width", int'(done_o), 1);
      @(negedge clk);
      chk("R7 done falls", int'(done_o), 0);
      for (int i = 0; i < 5; i++) begin
         vec_i = one_bit(10 * i + 400); serial_i = ~serial_i;
         @(negedge clk);
         if (done_o) pulses++;
      end
      chk("R7 pos held", int'(pos_o), int'(p));
      chk("R7 hit held", int'(hit_o), 1);
      chk("R7 no pulse", pulses, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_parallel();
      t_serial();
      t_restart_ignored();
      t_mode_change();
      t_hold();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule